// File: doc/BRIEF.md
# Domain Permission Cache with Fence

This block keeps recent permission results for physical pages, each tagged with the supervisor domain identifier it belongs to. It is fully associative and small. A walker outside the block fetches permissions from the in-memory table and installs them through a fill port. The access path then asks the lookup port whether a given (domain, page) pair is cached and which permission bits apply. The lookup answer is combinational and comes in the same cycle.

Fence requests arrive on one invalidation port. Each request carries an address operand, a domain operand, a flag for each operand telling whether its source register was x0, and a flag telling whether the requester runs in machine mode. The two flags select the scope of the fence: everything, one page across all domains, one domain, or one page of one domain. The block clears the covered entries at the next clock edge and raises a one-cycle done pulse in the cycle that follows. A request that does not come from machine mode is refused with an illegal-instruction pulse. A build-time option reduces every fence to a full flush.

Top module: `domPermCache`

## Requirements
- R1: While reset is held, and in the first cycle after it, no entry is valid, `lkHit` is 0, and `invDone` and `invIllegal` are 0.
- R2: `lkHit` is 1 in the same cycle as `lkValid` when a valid entry holds exactly `lkSdid` and `lkPpn`, and `lkPerm` then shows that entry's permission bits. Otherwise `lkHit` is 0 and `lkPerm` is 0.
- R3: A fill takes effect at the next clock edge. A fill of a pair that is already cached overwrites that entry's permission bits in place and does not take a second entry.
- R4: A fill of a new pair goes to the lowest-numbered invalid entry. When every entry is valid, the fill replaces the entry at a rotating pointer. The pointer starts at 0 after reset and moves up by one, modulo the entry count, on each such eviction.
- R5: A machine-mode fence with `invRs1Zero`=1 and `invRs2Zero`=1 invalidates every entry of every domain. This is the scope that a protection-mode change uses.
- R6: A machine-mode fence with `invRs1Zero`=0 and `invRs2Zero`=1 invalidates, in all domains, the entries whose page equals `invPaddr[PA_W-1:PAGE_SHIFT]`. The low `PAGE_SHIFT` bits of the address are ignored.
- R7: A machine-mode fence with `invRs1Zero`=1 and `invRs2Zero`=0 invalidates every entry whose identifier equals `invRs2[SDID_LEN-1:0]`. All higher bits of `invRs2` are ignored.
- R8: A machine-mode fence with both zero flags at 0 invalidates only the entries that match both the page and the identifier. Entries that match only one of them stay cached.
- R9: A machine-mode request gives `invDone`=1 for exactly the next cycle. Lookups from that cycle on do not hit an invalidated entry.
- R10: A request with `invMachine`=0 gives `invIllegal`=1 for exactly the next cycle, keeps `invDone` at 0, and removes no entry.
- R11: A fill in the same cycle as a machine-mode fence whose scope covers the fill's pair is dropped and evicts nothing. A fill that the fence does not cover is installed.
- R12: With `GLOBAL_ONLY`=1, every machine-mode fence invalidates all entries, whatever the operand flags and values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | Lookup request |
| lkSdid | input | SDID_LEN | Domain identifier to look up |
| lkPpn | input | PA_W-PAGE_SHIFT | Physical page to look up |
| lkHit | output | 1 | Lookup found a valid matching entry |
| lkPerm | output | PERM_W | Permission bits of the hit entry, 0 on a miss |
| fillValid | input | 1 | Install request from the table walker |
| fillSdid | input | SDID_LEN | Domain identifier of the fill |
| fillPpn | input | PA_W-PAGE_SHIFT | Physical page of the fill |
| fillPerm | input | PERM_W | Permission bits to install |
| invValid | input | 1 | Fence request |
| invMachine | input | 1 | Requester runs in machine mode |
| invRs1Zero | input | 1 | Address operand register was x0 |
| invRs2Zero | input | 1 | Domain operand register was x0 |
| invPaddr | input | PA_W | Address operand |
| invRs2 | input | XLEN | Domain operand, only the low SDID_LEN bits used |
| invDone | output | 1 | Fence applied, one-cycle pulse |
| invIllegal | output | 1 | Fence refused as illegal, one-cycle pulse |

## Verification
The assertions check, on every cycle, the properties that are local in time. These are the reset state, the one-cycle done and illegal pulses and their causes, a miss that shows no permission bits, a global fence that leaves no entry valid, and an illegal request that leaves the valid set unchanged. Which entries a scoped fence removes, what replacement does, and the fill-against-fence priority all depend on the exact cached contents. Only the bench scenarios can show these, by comparing lookups against a model of entries and pointer under directed corner cases and a seeded random mix of fills, lookups and fences of every scope. The full-flush variant is shown by a second instance that receives the same stimulus.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic invApply;   // legal fence this cycle
    logic useAddr;    // restrict to one page
    logic useSdid;    // restrict to one domain
    logic fillEn;     // fill offered this cycle
  } dpcStrobe_t;

endpackage

// File: rtl/dpcCtrl.sv
module dpcCtrl
  import dpc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter bit GLOBAL_ONLY = 1'b0,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             invValid,
  input  logic             invMachine,
  input  logic             invRs1Zero,
  input  logic             invRs2Zero,
  input  logic             fillValid,
  input  logic             evictNow,
  output dpcStrobe_t       strobe,
  output logic [IDX_W-1:0] rrPtr,
  output logic             invDone,
  output logic             invIllegal
);

  logic legalFence;
  assign legalFence = invValid && invMachine;

  generate
    if (GLOBAL_ONLY) begin : gScopeFlush
      assign strobe.useAddr = 1'b0;
      assign strobe.useSdid = 1'b0;
    end else begin : gScopeFull
      assign strobe.useAddr = !invRs1Zero;
      assign strobe.useSdid = !invRs2Zero;
    end
  endgenerate

  assign strobe.invApply = legalFence;
  assign strobe.fillEn   = fillValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      invDone    <= 1'b0;
      invIllegal <= 1'b0;
      rrPtr      <= '0;
    end else begin
      invDone    <= legalFence;
      invIllegal <= invValid && !invMachine;
      if (evictNow) begin
        if (rrPtr == IDX_W'(NUM_ENTRIES - 1)) rrPtr <= '0;
        else                                  rrPtr <= rrPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dpcData.sv
module dpcData
  import dpc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int SDID_LEN    = 6,
  parameter int PPN_W       = 22,
  parameter int PERM_W      = 2,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpcStrobe_t          strobe,
  input  logic [IDX_W-1:0]    rrPtr,
  input  logic [SDID_LEN-1:0] lkSdid,
  input  logic [PPN_W-1:0]    lkPpn,
  input  logic [SDID_LEN-1:0] fillSdid,
  input  logic [PPN_W-1:0]    fillPpn,
  input  logic [PERM_W-1:0]   fillPerm,
  input  logic [SDID_LEN-1:0] invSdid,
  input  logic [PPN_W-1:0]    invPpn,
  output logic                lkMatch,
  output logic [PERM_W-1:0]   lkPermRaw,
  output logic                evictNow
);

  logic [NUM_ENTRIES-1:0] entValid;
  logic [SDID_LEN-1:0]    eSdid [NUM_ENTRIES];
  logic [PPN_W-1:0]       ePpn  [NUM_ENTRIES];
  logic [PERM_W-1:0]      ePerm [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] lkHitV, fillHitV, invHitV, writeV;

  // Per-entry comparators
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEntry
    assign lkHitV[i]   = entValid[i] && (eSdid[i] == lkSdid) && (ePpn[i] == lkPpn);
    assign fillHitV[i] = entValid[i] && (eSdid[i] == fillSdid) && (ePpn[i] == fillPpn);
    assign invHitV[i]  = strobe.invApply && entValid[i]
                      && (!strobe.useAddr || (ePpn[i] == invPpn))
                      && (!strobe.useSdid || (eSdid[i] == invSdid));
  end

  assign lkMatch = |lkHitV;

  always_comb begin
    lkPermRaw = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lkHitV[i]) lkPermRaw = lkPermRaw | ePerm[i];
    end
  end

  // Victim choice: existing pair, then lowest free slot, then rotating pointer
  logic             fillAny, anyFree, fillKilled, install;
  logic [IDX_W-1:0] fillIdx, freeIdx, victim;

  always_comb begin
    fillAny = 1'b0;
    anyFree = 1'b0;
    fillIdx = '0;
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (fillHitV[i]) begin
        fillAny = 1'b1;
        fillIdx = IDX_W'(i);
      end
      if (!entValid[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
    victim = fillAny ? fillIdx : (anyFree ? freeIdx : rrPtr);
  end

  // A fill covered by a concurrent legal fence is dropped
  assign fillKilled = strobe.invApply
                   && (!strobe.useAddr || (fillPpn == invPpn))
                   && (!strobe.useSdid || (fillSdid == invSdid));
  assign install  = strobe.fillEn && !fillKilled;
  assign writeV   = install ? (NUM_ENTRIES'(1) << victim) : '0;
  assign evictNow = install && !fillAny && !anyFree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        eSdid[i] <= '0;
        ePpn[i]  <= '0;
        ePerm[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (writeV[i]) begin
          entValid[i] <= 1'b1;
          eSdid[i]    <= fillSdid;
          ePpn[i]     <= fillPpn;
          ePerm[i]    <= fillPerm;
        end else if (invHitV[i]) begin
          entValid[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/domPermCache.sv
module domPermCache
  import dpc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int PA_W        = 34,
  parameter int PAGE_SHIFT  = 12,
  parameter int SDID_LEN    = 6,
  parameter int XLEN        = 32,
  parameter int PERM_W      = 2,
  parameter bit GLOBAL_ONLY = 1'b0,
  localparam int PPN_W = PA_W - PAGE_SHIFT,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lkValid,
  input  logic [SDID_LEN-1:0] lkSdid,
  input  logic [PPN_W-1:0]    lkPpn,
  output logic                lkHit,
  output logic [PERM_W-1:0]   lkPerm,
  input  logic                fillValid,
  input  logic [SDID_LEN-1:0] fillSdid,
  input  logic [PPN_W-1:0]    fillPpn,
  input  logic [PERM_W-1:0]   fillPerm,
  input  logic                invValid,
  input  logic                invMachine,
  input  logic                invRs1Zero,
  input  logic                invRs2Zero,
  input  logic [PA_W-1:0]     invPaddr,
  input  logic [XLEN-1:0]     invRs2,
  output logic                invDone,
  output logic                invIllegal
);

  dpcStrobe_t          strobe;
  logic [IDX_W-1:0]    rrPtr;
  logic                evictNow, lkMatch;
  logic [PERM_W-1:0]   lkPermRaw;
  logic [SDID_LEN-1:0] invSdid;
  logic [PPN_W-1:0]    invPpn;
  logic                unusedOperandBits;

  // Only implemented identifier bits and the page number take part
  assign invSdid = invRs2[SDID_LEN-1:0];
  assign invPpn  = invPaddr[PA_W-1:PAGE_SHIFT];
  assign unusedOperandBits = ^{invRs2[XLEN-1:SDID_LEN], invPaddr[PAGE_SHIFT-1:0]};

  dpcCtrl #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .GLOBAL_ONLY(GLOBAL_ONLY)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .invValid  (invValid),
    .invMachine(invMachine),
    .invRs1Zero(invRs1Zero),
    .invRs2Zero(invRs2Zero),
    .fillValid (fillValid),
    .evictNow  (evictNow),
    .strobe    (strobe),
    .rrPtr     (rrPtr),
    .invDone   (invDone),
    .invIllegal(invIllegal)
  );

  dpcData #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .SDID_LEN   (SDID_LEN),
    .PPN_W      (PPN_W),
    .PERM_W     (PERM_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rrPtr    (rrPtr),
    .lkSdid   (lkSdid),
    .lkPpn    (lkPpn),
    .fillSdid (fillSdid),
    .fillPpn  (fillPpn),
    .fillPerm (fillPerm),
    .invSdid  (invSdid),
    .invPpn   (invPpn),
    .lkMatch  (lkMatch),
    .lkPermRaw(lkPermRaw),
    .evictNow (evictNow)
  );

  assign lkHit  = lkValid && lkMatch;
  assign lkPerm = lkHit ? lkPermRaw : '0;

endmodule

// File: rtl/domPermCacheChk.sv
module domPermCacheChk #(
  parameter int NUM_ENTRIES = 8,
  parameter int PERM_W      = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   invValid,
  input logic                   invMachine,
  input logic                   invRs1Zero,
  input logic                   invRs2Zero,
  input logic                   fillValid,
  input logic                   lkHit,
  input logic [PERM_W-1:0]      lkPerm,
  input logic                   invDone,
  input logic                   invIllegal,
  input logic [NUM_ENTRIES-1:0] entValid
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (entValid == '0 && !invDone && !invIllegal)); // R1

  AST_MISS_NO_PERM: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkPerm == '0)); // R2

  AST_GLOBAL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && invMachine && invRs1Zero && invRs2Zero) |=> (entValid == '0)); // R5

  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && invMachine) |=> (invDone && !invIllegal)); // R9

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    invDone |-> $past(invValid && invMachine)); // R9

  AST_ILLEGAL_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !invMachine) |=> (invIllegal && !invDone)); // R10

  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !invMachine && !fillValid) |=> (entValid == $past(entValid))); // R10

endmodule

bind domPermCache domPermCacheChk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .PERM_W     (PERM_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .invValid  (invValid),
  .invMachine(invMachine),
  .invRs1Zero(invRs1Zero),
  .invRs2Zero(invRs2Zero),
  .fillValid (fillValid),
  .lkHit     (lkHit),
  .lkPerm    (lkPerm),
  .invDone   (invDone),
  .invIllegal(invIllegal),
  .entValid  (uData.entValid)
);

// File: tb/domPermCache_test.sv
module domPermCache_test;

  localparam int N     = 8;
  localparam int PA_W  = 34;
  localparam int PS    = 12;
  localparam int SL    = 6;
  localparam int XL    = 32;
  localparam int PW    = 2;
  localparam int PPN_W = PA_W - PS;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic            rstN;
  logic            lkValid;
  logic [SL-1:0]   lkSdid;
  logic [PPN_W-1:0] lkPpn;
  logic            lkHit, lkHitG;
  logic [PW-1:0]   lkPerm, lkPermG;
  logic            fillValid;
  logic [SL-1:0]   fillSdid;
  logic [PPN_W-1:0] fillPpn;
  logic [PW-1:0]   fillPerm;
  logic            invValid, invMachine, invRs1Zero, invRs2Zero;
  logic [PA_W-1:0] invPaddr;
  logic [XL-1:0]   invRs2;
  logic            invDone, invIllegal, invDoneG, invIllegalG;

  domPermCache #(.NUM_ENTRIES(N), .PA_W(PA_W), .PAGE_SHIFT(PS), .SDID_LEN(SL),
                 .XLEN(XL), .PERM_W(PW), .GLOBAL_ONLY(1'b0)) uut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkSdid(lkSdid), .lkPpn(lkPpn),
    .lkHit(lkHit), .lkPerm(lkPerm), .fillValid(fillValid), .fillSdid(fillSdid),
    .fillPpn(fillPpn), .fillPerm(fillPerm), .invValid(invValid), .invMachine(invMachine),
    .invRs1Zero(invRs1Zero), .invRs2Zero(invRs2Zero), .invPaddr(invPaddr),
    .invRs2(invRs2), .invDone(invDone), .invIllegal(invIllegal));

  domPermCache #(.NUM_ENTRIES(N), .PA_W(PA_W), .PAGE_SHIFT(PS), .SDID_LEN(SL),
                 .XLEN(XL), .PERM_W(PW), .GLOBAL_ONLY(1'b1)) uutG (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkSdid(lkSdid), .lkPpn(lkPpn),
    .lkHit(lkHitG), .lkPerm(lkPermG), .fillValid(fillValid), .fillSdid(fillSdid),
    .fillPpn(fillPpn), .fillPerm(fillPerm), .invValid(invValid), .invMachine(invMachine),
    .invRs1Zero(invRs1Zero), .invRs2Zero(invRs2Zero), .invPaddr(invPaddr),
    .invRs2(invRs2), .invDone(invDoneG), .invIllegal(invIllegalG));

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  // Expected-state model of the cache (uut only)
  bit               mV    [N];
  logic [SL-1:0]    mS    [N];
  logic [PPN_W-1:0] mP    [N];
  logic [PW-1:0]    mPerm [N];
  int               mRr = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mFind(input logic [SL-1:0] s, input logic [PPN_W-1:0] p);
    int idx = -1;
    for (int i = 0; i < N; i++) if (mV[i] && mS[i] == s && mP[i] == p) idx = i;
    return idx;
  endfunction

  function automatic void mStep(input bit fOn, input logic [SL-1:0] fs, input logic [PPN_W-1:0] fp,
                                input logic [PW-1:0] fperm, input bit iOn, input bit r1z,
                                input bit r2z, input logic [PA_W-1:0] pa, input logic [XL-1:0] r2);
    int hitI;
    int freeI;
    int v;
    bit kill;
    logic [PPN_W-1:0] ip;
    logic [SL-1:0] isd;
    ip = pa[PA_W-1:PS];
    isd = r2[SL-1:0];
    hitI = mFind(fs, fp);
    freeI = -1;
    for (int i = N - 1; i >= 0; i--) if (!mV[i]) freeI = i;
    kill = iOn && (r1z || fp == ip) && (r2z || fs == isd);
    if (iOn)
      for (int i = 0; i < N; i++)
        if (mV[i] && (r1z || mP[i] == ip) && (r2z || mS[i] == isd)) mV[i] = 1'b0;
    if (fOn && !kill) begin
      if (hitI >= 0)       v = hitI;
      else if (freeI >= 0) v = freeI;
      else begin
        v = mRr;
        mRr = (mRr + 1) % N;
      end
      mV[v] = 1'b1; mS[v] = fs; mP[v] = fp; mPerm[v] = fperm;
    end
  endfunction

  task automatic clearIn();
    lkValid = 0; fillValid = 0; invValid = 0;
  endtask

  task automatic lookupChk(input bit waitEdge, input logic [SL-1:0] s, input logic [PPN_W-1:0] p,
                           input string tag);
    int idx;
    if (waitEdge) begin
      @(negedge clk);
      clearIn();
    end
    lkValid = 1; lkSdid = s; lkPpn = p;
    #1;
    idx = mFind(s, p);
    check(lkHit == (idx >= 0), {tag, " hit"}, lkHit, idx >= 0);
    check(lkPerm == ((idx >= 0) ? mPerm[idx] : '0), {tag, " perm"}, lkPerm,
          (idx >= 0) ? mPerm[idx] : 0);
  endtask

  task automatic fill(input logic [SL-1:0] s, input logic [PPN_W-1:0] p, input logic [PW-1:0] pm);
    @(negedge clk);
    clearIn();
    fillValid = 1; fillSdid = s; fillPpn = p; fillPerm = pm;
    mStep(1, s, p, pm, 0, 1, 1, '0, '0);
  endtask

  task automatic fence(input bit mach, input bit r1z, input bit r2z, input logic [PA_W-1:0] pa,
                       input logic [XL-1:0] r2, input bit wf, input logic [SL-1:0] fs,
                       input logic [PPN_W-1:0] fp, input logic [PW-1:0] fperm, input string tag);
    @(negedge clk);
    clearIn();
    invValid = 1; invMachine = mach; invRs1Zero = r1z; invRs2Zero = r2z;
    invPaddr = pa; invRs2 = r2;
    fillValid = wf; fillSdid = fs; fillPpn = fp; fillPerm = fperm;
    mStep(wf, fs, fp, fperm, mach, r1z, r2z, pa, r2);
    @(negedge clk);
    clearIn();
    check(invDone == mach, {tag, " done"}, invDone, mach);
    check(invIllegal == !mach, {tag, " illegal"}, invIllegal, !mach);
  endtask

  task automatic lookupAll(input string tag);
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 6; p++) lookupChk(1, SL'(s), PPN_W'(p), tag);
  endtask

  function automatic logic [PA_W-1:0] mkPa(input int p, input int off);
    return {PPN_W'(p), PS'(off)};
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int r;
    for (int i = 0; i < N; i++) mV[i] = 1'b0;
    rstN = 0;
    clearIn();
    invMachine = 0; invRs1Zero = 1; invRs2Zero = 1; invPaddr = '0; invRs2 = '0;
    lkSdid = '0; lkPpn = '0; fillSdid = '0; fillPpn = '0; fillPerm = '0;
    repeat (3) @(negedge clk);
    check(invDone == 0 && invIllegal == 0, "R1 reset pulses", {invDone, invIllegal}, 0);
    rstN = 1;
    lookupChk(0, 0, 0, "R1 empty after reset");

    // R2 R3: fill all slots, then refill one in place
    for (int i = 0; i < N; i++) fill(SL'(i % 4), PPN_W'(i / 4), PW'(i % 4));
    lookupAll("R2 full lookups");
    fill(2, 0, 2'd1);
    lookupAll("R3 refill in place");
    // R4: evictions follow the rotating pointer
    fill(3, 5, 2'd3);
    lookupAll("R4 first eviction");
    fill(0, 5, 2'd2);
    lookupAll("R4 second eviction");
    // R10: illegal request changes nothing
    fence(0, 1, 1, '0, '0, 0, 0, 0, 0, "R10 illegal");
    lookupAll("R10 no removal");
    // R6: address scope, offset bits ignored
    fence(1, 0, 1, mkPa(1, 12'hABC), '0, 0, 0, 0, 0, "R6 page fence");
    lookupChk(0, 1, 1, "R9 miss in done cycle");
    lookupAll("R6 page fence");
    // R4: fills go to the lowest free slots
    fill(1, 1, 2'd1);
    fill(2, 2, 2'd2);
    fill(3, 3, 2'd3);
    lookupAll("R4 free slot reuse");
    // R7: domain scope, high operand bits ignored
    fence(1, 1, 0, mkPa(4, 0), {26'h2AAAAAA, 6'd3}, 0, 0, 0, 0, "R7 domain fence");
    lookupAll("R7 domain fence");
    // R8: page and domain together
    fill(1, 2, 2'd2);
    fill(2, 2, 2'd3);
    fence(1, 0, 0, mkPa(2, 5), 32'd2, 0, 0, 0, 0, "R8 pair fence");
    lookupAll("R8 pair fence");
    // R11: covered fill dropped, uncovered fill kept
    fence(1, 1, 0, '0, 32'd1, 1, 1, 4, 2'd1, "R11 covered fill");
    lookupChk(1, 1, 4, "R11 covered fill dropped");
    fence(1, 1, 0, '0, 32'd1, 1, 2, 4, 2'd2, "R11 uncovered fill");
    lookupChk(1, 2, 4, "R11 uncovered fill kept");
    // R5: global fence
    fence(1, 1, 1, mkPa(3, 0), 32'd3, 0, 0, 0, 0, "R5 global fence");
    lookupAll("R5 global fence");

    // Seeded random mix
    r = $urandom(32'h5EED_0424);
    for (int it = 0; it < 800; it++) begin
      int op;
      op = $urandom % 5;
      if (op < 2) begin
        lookupChk(1, SL'($urandom % 4), PPN_W'($urandom % 6), "R2 random lookup");
      end else if (op < 4) begin
        fill(SL'($urandom % 4), PPN_W'($urandom % 6), PW'($urandom));
      end else begin
        bit mach;
        mach = ($urandom % 8) != 0;
        fence(mach, 1'($urandom), 1'($urandom), mkPa($urandom % 6, $urandom % 4096),
              {26'($urandom), 6'($urandom % 4)}, 1'($urandom), SL'($urandom % 4),
              PPN_W'($urandom % 6), PW'($urandom), "R5-8 random fence");
        lookupChk(0, SL'($urandom % 4), PPN_W'($urandom % 6), "R9 random after done");
      end
    end

    // R12: flush-only variant ignores the narrowed scope
    fill(1, 1, 2'd3);
    fence(1, 0, 0, mkPa(3, 0), 32'd2, 0, 0, 0, 0, "R12 narrow fence");
    lookupChk(0, 1, 1, "R12 main instance keeps entry");
    check(lkHitG == 0, "R12 flush-only instance miss", lkHitG, 0);
    check(invDoneG == 1, "R12 flush-only done", invDoneG, 1);

    @(negedge clk);
    summary();
  end

endmodule